// File: doc/BRIEF.md
# Shared DRAM Port Arbiter

This controller lets a processor and a sample acquisition path share one 64K-byte dynamic memory. In every idle cycle it decides which of three users gets the array next: the refresh engine, the acquisition path, or the processor. The winner's address and data are latched and driven onto the memory lines. A processor cycle takes its address from the processor bus. An acquisition store takes its address from an internal counter that advances after each completed store.

Each access splits the 16-bit byte address into two halves on one 8-bit address bus. The upper half (bits 15:8) goes out as the row while RAS is low. The lower half (bits 7:0) follows as the column one cycle later, while both RAS and CAS are low. A precharge cycle with all strobes high ends every access. Refresh is a RAS-only cycle: the row comes from an internal 8-bit counter, and CAS and WE stay high. A refresh request is raised every `REFRESH_INTERVAL` clocks.

The processor holds `cpu_req` high until it sees `cpu_ready`. The acquisition path holds `acq_req` high until it sees `acq_ack`. Each of these acknowledges is a one-cycle pulse in the precharge cycle. Strobes are active low.

Top module: `dram_arbiter`

## Requirements
- R1: While reset is held and just after it is released, `mem_ras_n`, `mem_cas_n` and `mem_we_n` are all 1, `cpu_ready` and `acq_ack` are 0, and the sample address is 0.
- R2: Every access drives the row `addr[15:8]` on `mem_addr` with RAS low and CAS high. In the next cycle it drives the column `addr[7:0]` with RAS and CAS both low. A precharge cycle with all strobes high follows.
- R3: A processor access uses `cpu_addr`. For a write, `mem_we_n` is 0 during the column cycle and `mem_dout` carries `cpu_wdata`. For a read, `mem_we_n` stays 1, and the value on `mem_din` during the column cycle appears on `cpu_rdata` when `cpu_ready` is 1.
- R4: An acquisition store writes `acq_data` to the address held by the internal sample counter, with `mem_we_n` 0 in the column cycle.
- R5: After each completed store (the `acq_ack` cycle), the sample address advances by one, modulo 65536.
- R6: A one-cycle `acq_addr_clr` pulse sets the sample address to 0. If the clear and a store completion fall in the same cycle, the clear wins.
- R7: When several requests are pending in an idle cycle, refresh is served first, then the acquisition store, then the processor.
- R8: A refresh request is raised every `REFRESH_INTERVAL` clocks. Refresh is RAS-only: CAS and WE stay high. Its row comes from an 8-bit counter that starts at 0 and advances by one after each refresh.
- R9: `cpu_ready` (and likewise `acq_ack`) is a single-cycle pulse that comes only after that requester's column cycle has completed. The two are never 1 together.
- R10: `mem_cas_n` is never 0 while `mem_ras_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_we | input | 1 | 1 = processor write, 0 = read |
| cpu_addr | input | 16 | Processor byte address |
| cpu_wdata | input | 8 | Processor write data |
| cpu_rdata | output | 8 | Processor read data, valid with cpu_ready |
| cpu_ready | output | 1 | Processor cycle completed |
| acq_req | input | 1 | Acquisition store request, held until ack |
| acq_data | input | 8 | Sample byte to store |
| acq_addr_clr | input | 1 | Clear the sample address counter |
| acq_ack | output | 1 | Store completed |
| mem_addr | output | 8 | Multiplexed row/column address |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dout | output | 8 | Data to the memory |
| mem_din | input | 8 | Data from the memory |

## Verification
The collision that matters is a refresh tick and a waiting acquisition store landing in the same idle cycle. Refresh must take the slot, and the store must go out next at its unchanged address. The bench provokes this by streaming many stores back to back, so that every refresh tick falls while a store is waiting. It then checks two things: enough RAS-only cycles still occurred for the elapsed clocks, and the store addresses stayed contiguous with no store lost. A second pairing is a store completion and a counter clear in the same cycle. The bench raises the clear on the acknowledge cycle and expects the next store at address 0.

// File: rtl/dram_arb_pkg.sv
package dram_arb_pkg;

    localparam int ADDR_W = 16;
    localparam int ROW_W  = 8;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        GNT_NONE = 2'd0,
        GNT_REF  = 2'd1,
        GNT_ACQ  = 2'd2,
        GNT_CPU  = 2'd3
    } grant_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ROW  = 2'd1,
        ST_COL  = 2'd2,
        ST_PRE  = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              wr;
    } mem_op_t;

    function automatic logic [ROW_W-1:0] row_half(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: ROW_W];
    endfunction

    function automatic logic [ROW_W-1:0] col_half(input logic [ADDR_W-1:0] a);
        return a[ROW_W-1:0];
    endfunction

endpackage

// File: rtl/refresh_timer.sv
module refresh_timer
    import dram_arb_pkg::*;
#(
    parameter int INTERVAL = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_taken,
    input  logic             ref_done,
    output logic             ref_pend,
    output logic [ROW_W-1:0] ref_row
);
    localparam int CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

    logic [CNT_W-1:0] tick_cnt;
    logic             tick;

    assign tick = (tick_cnt == CNT_W'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_cnt <= '0;
            ref_pend <= 1'b0;
            ref_row  <= '0;
        end else begin
            tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
            ref_pend <= tick | (ref_pend & ~ref_taken);
            if (ref_done)
                ref_row <= ref_row + 1'b1;
        end
    end

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (rst)
        ref_done |=> ref_row == $past(ref_row) + 1'b1) else $error("row step"); // R8

    AST_PEND_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        tick |=> ref_pend) else $error("pend"); // R8

endmodule

// File: rtl/sample_addr_counter.sv
module sample_addr_counter
    import dram_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            addr <= '0;
        else if (inc)
            addr <= addr + 1'b1;
    end

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (inc && !clr) |=> addr == $past(addr) + 1'b1) else $error("step"); // R5

    AST_ADDR_CLR: assert property (@(posedge clk) disable iff (rst)
        clr |=> addr == '0) else $error("clr"); // R6

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!inc && !clr) |=> $stable(addr)) else $error("hold"); // R5

endmodule

// File: rtl/dram_sequencer.sv
module dram_sequencer
    import dram_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_pend,
    input  logic [ROW_W-1:0]  ref_row,
    output logic              ref_taken,
    output logic              ref_done,
    input  logic              acq_req,
    input  logic [ADDR_W-1:0] acq_addr,
    input  logic [DATA_W-1:0] acq_data,
    output logic              acq_ack,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic [ROW_W-1:0]  mem_addr,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dout,
    input  logic [DATA_W-1:0] mem_din
);
    seq_state_t state;
    grant_t     grant;
    mem_op_t    op;

    assign ref_taken = (state == ST_IDLE) && ref_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            grant     <= GNT_NONE;
            op        <= '0;
            cpu_rdata <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (ref_pend) begin
                        grant <= GNT_REF;
                        op    <= '{addr: {ref_row, {(ADDR_W-ROW_W){1'b0}}}, data: '0, wr: 1'b0};
                        state <= ST_ROW;
                    end else if (acq_req) begin
                        grant <= GNT_ACQ;
                        op    <= '{addr: acq_addr, data: acq_data, wr: 1'b1};
                        state <= ST_ROW;
                    end else if (cpu_req) begin
                        grant <= GNT_CPU;
                        op    <= '{addr: cpu_addr, data: cpu_wdata, wr: cpu_we};
                        state <= ST_ROW;
                    end
                end
                ST_ROW:  state <= (grant == GNT_REF) ? ST_PRE : ST_COL;
                ST_COL: begin
                    if (grant == GNT_CPU && !op.wr)
                        cpu_rdata <= mem_din;
                    state <= ST_PRE;
                end
                default: begin
                    grant <= GNT_NONE;
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    assign mem_ras_n = !(state == ST_ROW || state == ST_COL);
    assign mem_cas_n = !(state == ST_COL);
    assign mem_we_n  = !(state == ST_COL && op.wr);
    assign mem_addr  = (state == ST_COL) ? col_half(op.addr) : row_half(op.addr);
    assign mem_dout  = op.data;
    assign ref_done  = (state == ST_PRE) && (grant == GNT_REF);
    assign acq_ack   = (state == ST_PRE) && (grant == GNT_ACQ);
    assign cpu_ready = (state == ST_PRE) && (grant == GNT_CPU);

    AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (rst)
        !mem_cas_n |-> !mem_ras_n) else $error("cas w/o ras"); // R10

    AST_READY_AFTER_CAS: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |-> $past(!mem_cas_n)) else $error("early ready"); // R9

    AST_ACK_AFTER_CAS: assert property (@(posedge clk) disable iff (rst)
        acq_ack |-> $past(!mem_cas_n)) else $error("early ack"); // R9

    AST_ONE_DONE: assert property (@(posedge clk) disable iff (rst)
        !(cpu_ready && acq_ack)) else $error("both done"); // R9

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
        cpu_ready |=> !cpu_ready) else $error("ready pulse"); // R9

    AST_REF_RAS_ONLY: assert property (@(posedge clk) disable iff (rst)
        (ref_pend && state == ST_IDLE) |=> (!mem_ras_n ##1 (mem_cas_n && mem_we_n)))
        else $error("refresh cas"); // R8

    AST_ROW_THEN_COL: assert property (@(posedge clk) disable iff (rst)
        !mem_cas_n |-> $past(!mem_ras_n && mem_cas_n)) else $error("order"); // R2

endmodule

// File: rtl/dram_arbiter.sv
module dram_arbiter
    import dram_arb_pkg::*;
#(
    parameter int REFRESH_INTERVAL = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    input  logic              acq_req,
    input  logic [DATA_W-1:0] acq_data,
    input  logic              acq_addr_clr,
    output logic              acq_ack,
    output logic [ROW_W-1:0]  mem_addr,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dout,
    input  logic [DATA_W-1:0] mem_din
);
    logic              ref_pend, ref_taken, ref_done;
    logic [ROW_W-1:0]  ref_row;
    logic [ADDR_W-1:0] sample_addr;

    refresh_timer #(.INTERVAL(REFRESH_INTERVAL)) u_refresh (
        .clk(clk), .rst(rst),
        .ref_taken(ref_taken), .ref_done(ref_done),
        .ref_pend(ref_pend), .ref_row(ref_row)
    );

    sample_addr_counter u_sample_addr (
        .clk(clk), .rst(rst),
        .clr(acq_addr_clr), .inc(acq_ack),
        .addr(sample_addr)
    );

    dram_sequencer u_seq (
        .clk(clk), .rst(rst),
        .ref_pend(ref_pend), .ref_row(ref_row),
        .ref_taken(ref_taken), .ref_done(ref_done),
        .acq_req(acq_req), .acq_addr(sample_addr), .acq_data(acq_data), .acq_ack(acq_ack),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_addr(mem_addr), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
        .mem_we_n(mem_we_n), .mem_dout(mem_dout), .mem_din(mem_din)
    );

endmodule

// File: tb/test_dram_arbiter.sv
`timescale 1ns/1ps
module test_dram_arbiter;
    localparam int INTERVAL = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_ready;
    logic        acq_req = 1'b0;
    logic [7:0]  acq_data = '0;
    logic        acq_addr_clr = 1'b0;
    logic        acq_ack;
    logic [7:0]  mem_addr;
    logic        mem_ras_n, mem_cas_n, mem_we_n;
    logic [7:0]  mem_dout;
    logic [7:0]  mem_din = '0;

    always #2.5 clk = ~clk;

    dram_arbiter #(.REFRESH_INTERVAL(INTERVAL)) i_dram_arbiter (
        .clk(clk), .rst(rst),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .acq_req(acq_req), .acq_data(acq_data), .acq_addr_clr(acq_addr_clr), .acq_ack(acq_ack),
        .mem_addr(mem_addr), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
        .mem_we_n(mem_we_n), .mem_dout(mem_dout), .mem_din(mem_din)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    always @(posedge clk) cyc++;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    typedef struct {
        int         addr;
        bit         wr;
        logic [7:0] data;
        bit         acq;
        string      tag;
    } exp_t;

    exp_t       sb_q[$];
    logic [7:0] model  [int];
    logic [7:0] shadow [int];
    int  exp_acq_addr = 0;
    int  exp_ref_row  = 0;
    int  ref_count    = 0;
    bit  cpu_cas_seen = 0;
    bit  acq_cas_seen = 0;

    // Monitor: memory model and scoreboard
    logic       ras_prev = 1'b1;
    logic [7:0] cur_row  = '0;
    bit         cas_in_ras = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_cas_n && mem_ras_n)
                check(0, "R10", "CAS without RAS", 1, 0);
            if (!mem_ras_n && ras_prev) begin
                cur_row    = mem_addr;
                cas_in_ras = 0;
                check(mem_cas_n, "R2", "CAS high in row cycle", mem_cas_n, 1);
            end
            if (!mem_cas_n) begin
                int a;
                exp_t e;
                a = {cur_row, mem_addr};
                cas_in_ras = 1;
                if (!mem_we_n) model[a] = mem_dout;
                else mem_din <= model.exists(a) ? model[a] : 8'h00;
                if (sb_q.size() == 0) begin
                    check(0, "R7", "unexpected column cycle", a, 0);
                end else begin
                    e = sb_q.pop_front();
                    check(a == e.addr, e.tag, "address", a, e.addr);
                    check(mem_we_n == !e.wr, e.tag, "we_n", mem_we_n, !e.wr);
                    if (e.wr) check(mem_dout == e.data, e.tag, "write data", mem_dout, e.data);
                    if (e.acq) acq_cas_seen = 1; else cpu_cas_seen = 1;
                end
            end
            if (mem_ras_n && !ras_prev && !cas_in_ras) begin
                check(cur_row == exp_ref_row[7:0], "R8", "refresh row", cur_row, exp_ref_row[7:0]);
                exp_ref_row = (exp_ref_row + 1) & 8'hFF;
                ref_count++;
            end
            ras_prev = mem_ras_n;
        end
    end

    task automatic wait_ready();
        forever begin
            @(negedge clk);
            if (cpu_ready) break;
        end
        check(cpu_cas_seen, "R9", "ready after column cycle", cpu_cas_seen, 1);
        cpu_cas_seen = 0;
        cpu_req = 1'b0;
    endtask

    task automatic wait_ack();
        forever begin
            @(negedge clk);
            if (acq_ack) break;
        end
        check(acq_cas_seen, "R9", "ack after column cycle", acq_cas_seen, 1);
        acq_cas_seen = 0;
        acq_req = 1'b0;
    endtask

    task automatic cpu_write(input int a, input logic [7:0] d);
        sb_q.push_back('{addr: a, wr: 1, data: d, acq: 0, tag: "R3"});
        shadow[a] = d;
        @(negedge clk);
        cpu_addr = a[15:0]; cpu_wdata = d; cpu_we = 1'b1; cpu_req = 1'b1;
        wait_ready();
    endtask

    task automatic cpu_read(input int a);
        logic [7:0] e;
        sb_q.push_back('{addr: a, wr: 0, data: 8'h00, acq: 0, tag: "R3"});
        e = shadow.exists(a) ? shadow[a] : 8'h00;
        @(negedge clk);
        cpu_addr = a[15:0]; cpu_we = 1'b0; cpu_req = 1'b1;
        wait_ready();
        check(cpu_rdata == e, "R3", "read data", cpu_rdata, e);
    endtask

    task automatic acq_store(input logic [7:0] d, input bit clr_on_ack);
        sb_q.push_back('{addr: exp_acq_addr, wr: 1, data: d, acq: 1, tag: "R4"});
        shadow[exp_acq_addr] = d;
        exp_acq_addr = (exp_acq_addr + 1) & 16'hFFFF;
        @(negedge clk);
        acq_data = d; acq_req = 1'b1;
        wait_ack();
        if (clr_on_ack) begin
            acq_addr_clr = 1'b1;   // R6: same cycle as completion, clear wins
            exp_acq_addr = 0;
            @(negedge clk);
            acq_addr_clr = 1'b0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int c0, r0;
        repeat (4) @(negedge clk);
        // R1: reset state
        check(mem_ras_n && mem_cas_n && mem_we_n, "R1", "strobes idle in reset",
              {mem_ras_n, mem_cas_n, mem_we_n}, 3'b111);
        check(!cpu_ready && !acq_ack, "R1", "no ready/ack in reset", {cpu_ready, acq_ack}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(mem_ras_n && mem_cas_n, "R1", "strobes idle after reset", {mem_ras_n, mem_cas_n}, 2'b11);

        // R1/R4/R5: first store lands at 0, then advances
        acq_store(8'hA1, 0);
        acq_store(8'hA2, 0);
        acq_store(8'hA3, 0);
        cpu_read(0);   // R4: sample visible to processor
        cpu_read(2);

        // R3: processor write/read, different rows and columns
        cpu_write(16'h12F0, 8'h5C);
        cpu_write(16'hFF01, 8'h3E);
        cpu_read(16'h12F0);
        cpu_read(16'hFF01);

        // R6: clear in the same cycle as a completion
        acq_store(8'hB0, 1);
        acq_store(8'hB1, 0);   // expected at address 0
        cpu_read(0);
        check(exp_acq_addr == 1, "R6", "bench counter after clear", exp_acq_addr, 1);

        // R7: acquisition and processor raised together
        sb_q.push_back('{addr: exp_acq_addr, wr: 1, data: 8'hC7, acq: 1, tag: "R7"});
        shadow[exp_acq_addr] = 8'hC7;
        exp_acq_addr = exp_acq_addr + 1;
        sb_q.push_back('{addr: 16'h4242, wr: 1, data: 8'h99, acq: 0, tag: "R7"});
        shadow[16'h4242] = 8'h99;
        @(negedge clk);
        acq_data = 8'hC7; acq_req = 1'b1;
        cpu_addr = 16'h4242; cpu_wdata = 8'h99; cpu_we = 1'b1; cpu_req = 1'b1;
        fork
            wait_ack();
            wait_ready();
        join
        cpu_read(16'h4242);

        // R8: refresh cadence while idle
        r0 = ref_count;
        repeat (10 * INTERVAL) @(negedge clk);
        check(ref_count - r0 >= 9 && ref_count - r0 <= 11, "R8", "idle refresh count",
              ref_count - r0, 10);

        // R7/R8: stores streamed so refresh ticks collide with waiting stores
        r0 = ref_count;
        c0 = cyc;
        for (int i = 0; i < 40; i++) acq_store(8'(8'h10 + i), 0);
        check(ref_count - r0 >= (cyc - c0) / INTERVAL - 1, "R8", "refresh under load",
              ref_count - r0, (cyc - c0) / INTERVAL);
        cpu_read(exp_acq_addr - 1);
        cpu_read(exp_acq_addr - 40);
        check(sb_q.size() == 0, "R7", "all expected cycles seen", sb_q.size(), 0);

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule